// File: doc/BRIEF.md
# Gated ring time-to-digital quantizer

This block is a synthesizable digital model of a gated-ring time-to-digital converter. It is one lane of a quantizer whose analog input arrives as pulse-width-modulated pulses. A phase ring of 21 stages moves forward by one stage on each fast-clock edge while the gate input is high. While the gate is low, the ring keeps its state, and it is never cleared between sample periods.

Once per sample period a strobe captures the ring phases. A second register stage then resynchronizes the capture. The resynchronized snapshot is XORed with the one from the period before. The resulting 21-bit word has one set bit for each gated tick. Its set bits form a run that continues around the ring from where the previous word stopped, which gives a rotating, data-weighted-averaging pattern to the feedback DAC elements. Of the 21 stages, 16 cover the signal range and 5 absorb a fixed pulse-width offset, and all 21 bits are exported.

A full quantizer uses two instances of this block, one fed by the UP pulse and one fed by the DN pulse.

Top module: `gated_ring_tdc`

## Requirements
- R1: A synchronous reset held high on a rising edge clears the ring and all snapshots. It also forces `therm_o`, `ones_o`, `sat_o` and `valid_o` to zero.
- R2: The ring toggles exactly one stage per rising edge at which `gate_i` is high. Stage k is toggled at the k-th gated tick since reset, counted from 0 and taken modulo 21. The ring holds its state on edges where `gate_i` is low, including the idle gaps between bursts within one period.
- R3: If `strobe_i` is high at rising edge E, `valid_o` is high for exactly one cycle, starting at edge E+1. The new output values appear at that same edge.
- R4: The first strobe after reset only primes the reference snapshot. It produces no `valid_o` pulse, and the outputs stay zero.
- R5: `therm_o` is the XOR of the two latest snapshots. For N gated ticks in a period with N of at most 21, bit positions (T+i) mod 21 are set for i = 0..N-1, where T is the number of gated ticks from reset up to the previous strobe. No other bit is set.
- R6: Successive words rotate. A run that passes bit 20 continues at bit 0.
- R7: For N of at most 21, `ones_o` equals N and `sat_o` is 0. N = 0 gives an all-zero word, and N = 21 gives all 21 bits set.
- R8: For N greater than 21, `ones_o` is clamped to 21 and `sat_o` is 1. `therm_o` still carries the raw XOR, which has 42 - N ones for N up to 42.
- R9: `therm_o`, `ones_o` and `sat_o` keep their values between `valid_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_i | input | 1 | Synchronous reset, active high |
| gate_i | input | 1 | PWM gate; the ring advances while it is high |
| strobe_i | input | 1 | Sample strobe, one per period |
| therm_o | output | 21 | Differentiated ring word |
| ones_o | output | 5 | Number of set bits, clamped to 21 |
| sat_o | output | 1 | More than 21 gated ticks occurred in the period |
| valid_o | output | 1 | One-cycle pulse marking a new word |

## Verification
The assertions assume that strobes are at least two cycles apart, so that one capture's resynchronizing stage never overlaps the next capture. The valid-pulse and hold properties depend on that spacing. The stimulus drives `gate_i` low on each strobe edge and separates strobes by several idle cycles. As a result, every gated tick belongs unambiguously to a single period, and the expected run position can be tracked as a running tick total from reset.

// File: rtl/gated_ring_tdc.sv
module gated_ring_tdc #(
  parameter int SIGNAL_STAGES = 16,
  parameter int OFFSET_STAGES = 5,
  localparam int STAGES = SIGNAL_STAGES + OFFSET_STAGES,
  localparam int CW = $clog2(STAGES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              gate_i,
  input  logic              strobe_i,
  output logic [STAGES-1:0] therm_o,
  output logic [CW-1:0]     ones_o,
  output logic              sat_o,
  output logic              valid_o
);

  localparam logic [CW-1:0] TICK_LIMIT = CW'(STAGES + 1);
  localparam logic [CW-1:0] FULL_SCALE = CW'(STAGES);

  logic [STAGES-1:0] ring_q, snap_a_q, snap_b_q;
  logic [CW-1:0]     ticks_q, ticks_hold_q;
  logic              cap_q, primed_q;

  function automatic logic [CW-1:0] popcount(input logic [STAGES-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < STAGES; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  wire [STAGES-1:0] diff_w = snap_a_q ^ snap_b_q;
  wire              over_w = ticks_hold_q > FULL_SCALE;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ring_q       <= '0;
      snap_a_q     <= '0;
      snap_b_q     <= '0;
      ticks_q      <= '0;
      ticks_hold_q <= '0;
      cap_q        <= 1'b0;
      primed_q     <= 1'b0;
      therm_o      <= '0;
      ones_o       <= '0;
      sat_o        <= 1'b0;
      valid_o      <= 1'b0;
    end else begin
      if (gate_i) ring_q <= {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};

      cap_q   <= strobe_i;
      valid_o <= cap_q && primed_q;

      if (strobe_i) begin
        snap_a_q     <= ring_q;
        ticks_hold_q <= ticks_q;
        ticks_q      <= gate_i ? CW'(1) : '0;
      end else if (gate_i && ticks_q != TICK_LIMIT) begin
        ticks_q <= ticks_q + CW'(1);
      end

      if (cap_q) begin
        snap_b_q <= snap_a_q;
        primed_q <= 1'b1;
        if (primed_q) begin
          therm_o <= diff_w;
          ones_o  <= over_w ? FULL_SCALE : popcount(diff_w);
          sat_o   <= over_w;
        end
      end
    end
  end

  assert_ring_one_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(ring_q ^ $past(ring_q)) <= 1);

  assert_ring_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !gate_i |=> $stable(ring_q));

  assert_valid_latency_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> $past(strobe_i, 2));

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  assert_strobe_spacing_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |=> !strobe_i);

  assert_ones_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ones_o <= FULL_SCALE);

  assert_sat_clamp_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    sat_o |-> ones_o == FULL_SCALE);

  assert_output_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> ($stable(therm_o) && $stable(ones_o) && $stable(sat_o)));

endmodule

// File: tb/gated_ring_tdc_tb_top.sv
`timescale 1ns/1ps
module gated_ring_tdc_tb_top;
  localparam int ST = 21;

  logic clk = 1'b0;
  logic rst, gate, strobe;
  logic [ST-1:0] therm;
  logic [4:0] ones;
  logic sat, valid;

  int checks = 0, failures = 0, total_ticks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gated_ring_tdc dut_i (
    .clk_i(clk), .rst_i(rst), .gate_i(gate), .strobe_i(strobe),
    .therm_o(therm), .ones_o(ones), .sat_o(sat), .valid_o(valid));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gate_burst(input int n);
    if (n > 0) begin
      @(negedge clk) gate = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk) gate = 1'b0;
      total_ticks += n;
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; gate = 1'b0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    total_ticks = 0;
    @(negedge clk);
    chk(valid == 0, "R1 valid", 32'(valid), 0);
    chk(therm == 0, "R1 therm", 32'(therm), 0);
    chk(ones == 0, "R1 ones", 32'(ones), 0);
    chk(sat == 0, "R1 sat", 32'(sat), 0);
  endtask

  task automatic prime_ref(input int pre_ticks);
    gate_burst(pre_ticks);
    repeat (2) @(negedge clk);
    strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(valid == 0, "R4 no valid on priming strobe", 32'(valid), 0);
    end
    chk(therm == 0, "R4 outputs stay zero", 32'(therm), 0);
  endtask

  task automatic run_period(input int n1, input int gap, input int n2, input string tag);
    int n, start;
    logic [ST-1:0] exp_w;
    logic [ST-1:0] w0;
    logic [4:0] o0;
    logic s0;
    n = n1 + n2;
    start = total_ticks;
    exp_w = '0;
    for (int i = 0; i < n; i++) exp_w[(start + i) % ST] ^= 1'b1;
    gate_burst(n1);
    repeat (gap) @(negedge clk);
    gate_burst(n2);
    repeat (2) @(negedge clk);
    strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
    chk(valid == 0, {"R3 early valid ", tag}, 32'(valid), 0);
    @(negedge clk);
    chk(valid == 1, {"R3 valid pulse ", tag}, 32'(valid), 1);
    chk(therm == exp_w, {"R5 word ", tag}, 32'(therm), 32'(exp_w));
    chk(ones == ((n > ST) ? 5'(ST) : 5'(n)), {"R7 ones ", tag}, 32'(ones), 32'((n > ST) ? ST : n));
    chk(sat == (n > ST), {"R8 sat ", tag}, 32'(sat), 32'(n > ST));
    w0 = therm; o0 = ones; s0 = sat;
    @(negedge clk);
    chk(valid == 0, {"R3 single pulse ", tag}, 32'(valid), 0);
    repeat (3) @(negedge clk);
    chk(therm == w0 && ones == o0 && sat == s0, {"R9 hold ", tag}, 32'(therm), 32'(w0));
  endtask

  task automatic test_wrap_R6;
    int start;
    start = total_ticks % ST;
    run_period(ST - start + 4, 0, 0, "R6 wrap");
    chk(therm[0] == 1 && therm[ST-1] == 1, "R6 run crosses bit 20", 32'(therm), 32'(1));
  endtask

  task automatic test_saturation_R8;
    run_period(25, 0, 0, "R8 over 21");
    chk($countones(therm) == 17, "R8 raw word ones", 32'($countones(therm)), 17);
  endtask

  initial begin
    do_reset();
    prime_ref(3);
    run_period(5, 0, 0, "R5 n5");
    run_period(0, 0, 0, "R7 zero");
    run_period(3, 6, 4, "R2 split bursts");
    run_period(16, 0, 0, "R5 n16");
    run_period(21, 0, 0, "R7 full scale");
    test_saturation_R8();
    test_wrap_R6();
    run_period(9, 2, 1, "R6 rotate");
    do_reset();
    prime_ref(0);
    run_period(7, 0, 0, "R1 after second reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule